// File: doc/BRIEF.md
# Two-Way Doorbell Interrupt Mailbox

This block carries interrupt requests between a host-facing function and an on-chip slave. Each side owns an eight-bit doorbell vector register. A write of ones to that register produces a one-cycle pulse, and the pulse latches the matching status bits on the opposite side. The vector register then empties itself, so software never has to clear it.

Each receiving side keeps a sticky raw status word, an enable word, a masked status word (raw AND enable) and a level interrupt output. Status bits are cleared by writing ones. The host-side status word also latches three local events: packet ready to send, receive-buffer overflow and send-buffer underflow. The slave-side status word latches two events: send-descriptor error and receive-descriptor error.

Register decode, the card protocol and the DMA engine stay outside this block. The block only sees strobed write data and pulsed event inputs.

Top module: `dbell_irq_mailbox`

## Requirements
- R1: While reset is asserted, and until the synchronized reset is released, every vector readback, raw status word and masked status word is zero and both interrupt outputs are low. The first cycle that can change state is the third rising clock edge after `rst_n` goes high.
- R2: After a vector write on one edge, the vector readback shows the written value until the next edge. After that edge it reads zero, unless another write occurs.
- R3: A host vector bit n sets slave raw status bit n at the edge after the readback shows it. A slave vector bit n sets host raw status bit n in the same way (n = 0..7).
- R4: Single-cycle host event pulses set host raw status bits at the next edge: packet ready to send sets bit 8, receive-buffer overflow sets bit 9, send-buffer underflow sets bit 10.
- R5: Single-cycle slave event pulses set slave raw status bits at the next edge: send-descriptor error sets bit 8, receive-descriptor error sets bit 9.
- R6: A raw status bit stays set until it is cleared.
- R7: A clear write clears every raw status bit whose data bit is 1. Data bits of 0, including an all-zero clear write, leave the status unchanged.
- R8: When a bit is set and cleared in the same cycle, the set wins. This holds for event pulses and for doorbell pulses.
- R9: An enable write replaces the whole enable word. The masked status equals raw status AND enable.
- R10: A side's interrupt output is high exactly while its masked status is nonzero. It is a level and follows clears without delay.
- R11: Zero bits in a vector write set no status bit on the far side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_ring_wr | input | 1 | Host writes its doorbell vector |
| h_ring_data | input | 8 | Host doorbell bits, ones ring the slave |
| h_ring_q | output | 8 | Host doorbell vector readback |
| h_en_wr | input | 1 | Host enable write strobe |
| h_en_data | input | 11 | Host enable word |
| h_clr_wr | input | 1 | Host clear write strobe |
| h_clr_data | input | 11 | Host clear bits, one clears |
| h_pkt_ready | input | 1 | Pulse: packet ready to send (bit 8) |
| h_rxbuf_ovf | input | 1 | Pulse: receive-buffer overflow (bit 9) |
| h_txbuf_udf | input | 1 | Pulse: send-buffer underflow (bit 10) |
| h_raw | output | 11 | Host raw status |
| h_masked | output | 11 | Host masked status |
| h_irq | output | 1 | Host interrupt level |
| s_ring_wr | input | 1 | Slave writes its doorbell vector |
| s_ring_data | input | 8 | Slave doorbell bits, ones ring the host |
| s_ring_q | output | 8 | Slave doorbell vector readback |
| s_en_wr | input | 1 | Slave enable write strobe |
| s_en_data | input | 10 | Slave enable word |
| s_clr_wr | input | 1 | Slave clear write strobe |
| s_clr_data | input | 10 | Slave clear bits, one clears |
| s_send_dscr_err | input | 1 | Pulse: send-descriptor error (bit 8) |
| s_recv_dscr_err | input | 1 | Pulse: receive-descriptor error (bit 9) |
| s_raw | output | 10 | Slave raw status |
| s_masked | output | 10 | Slave masked status |
| s_irq | output | 1 | Slave interrupt level |

## Verification
The bench builds the block with its default parameters: eight doorbell bits and a two-stage reset synchronizer. With these values every status bit position named in the requirements can be reached from a port, and the three-edge reset release is visible. A behavioural model, clocked alongside the design, predicts every output on every cycle. Directed sequences drive the cases the model alone would rarely produce: a set and a clear on one bit in the same cycle, enable words that cover no pending bit, and all-zero vector and clear writes.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned RING_W     = 8;
  localparam int unsigned H_EVT_N    = 3;
  localparam int unsigned S_EVT_N    = 2;
  localparam int unsigned H_STAT_W   = RING_W + H_EVT_N;
  localparam int unsigned S_STAT_W   = RING_W + S_EVT_N;
  // host event positions in the host status word
  localparam int unsigned H_PKT_BIT  = RING_W;
  localparam int unsigned H_OVF_BIT  = RING_W + 1;
  localparam int unsigned H_UDF_BIT  = RING_W + 2;
  // slave event positions in the slave status word
  localparam int unsigned S_SEND_BIT = RING_W;
  localparam int unsigned S_RECV_BIT = RING_W + 1;
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mbx_ring_reg.sv
module mbx_ring_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] ring_q
);
  logic [W-1:0] ring_d;

  // one-shot: holds written bits for one cycle then empties
  always_comb begin
    ring_d = '0;
    if (wr_i) ring_d = data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ring_q <= '0;
    else        ring_q <= ring_d;
  end

  assert_ring_selfclear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> ring_q == '0);
  assert_ring_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> ring_q == $past(data_i));
endmodule

// File: rtl/mbx_irq_bank.sv
module mbx_irq_bank #(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_wr_i,
  input  logic [W-1:0] clr_data_i,
  input  logic         en_wr_i,
  input  logic [W-1:0] en_data_i,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] masked_o,
  output logic         irq_o
);
  logic [W-1:0] raw_q, raw_d, en_q, en_d, clr_mask;
  logic         raw_ce, en_ce;

  always_comb begin
    clr_mask = clr_wr_i ? clr_data_i : '0;
    raw_ce   = (|set_i) | clr_wr_i;
    raw_d    = (raw_q & ~clr_mask) | set_i;  // set dominates
    en_ce    = en_wr_i;
    en_d     = en_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      raw_q <= '0;
    else if (raw_ce) raw_q <= raw_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  assign raw_o    = raw_q;
  assign masked_o = raw_q & en_q;
  assign irq_o    = |masked_o;

  assert_set_dominates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((raw_q & $past(set_i)) == $past(set_i)));
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr_i |=> ((raw_q & $past(raw_q)) == $past(raw_q)));
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr_i |=> ((raw_q & $past(clr_data_i & ~set_i)) == '0));
endmodule

// File: rtl/dbell_irq_mailbox.sv
module dbell_irq_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                h_ring_wr,
  input  logic [RING_W-1:0]   h_ring_data,
  output logic [RING_W-1:0]   h_ring_q,
  input  logic                h_en_wr,
  input  logic [H_STAT_W-1:0] h_en_data,
  input  logic                h_clr_wr,
  input  logic [H_STAT_W-1:0] h_clr_data,
  input  logic                h_pkt_ready,
  input  logic                h_rxbuf_ovf,
  input  logic                h_txbuf_udf,
  output logic [H_STAT_W-1:0] h_raw,
  output logic [H_STAT_W-1:0] h_masked,
  output logic                h_irq,
  input  logic                s_ring_wr,
  input  logic [RING_W-1:0]   s_ring_data,
  output logic [RING_W-1:0]   s_ring_q,
  input  logic                s_en_wr,
  input  logic [S_STAT_W-1:0] s_en_data,
  input  logic                s_clr_wr,
  input  logic [S_STAT_W-1:0] s_clr_data,
  input  logic                s_send_dscr_err,
  input  logic                s_recv_dscr_err,
  output logic [S_STAT_W-1:0] s_raw,
  output logic [S_STAT_W-1:0] s_masked,
  output logic                s_irq
);
  logic                rst_s_n;
  logic [H_STAT_W-1:0] h_set;
  logic [S_STAT_W-1:0] s_set;

  mbx_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n));

  mbx_ring_reg #(.W(RING_W)) u_h_ring (
    .clk(clk), .rst_n(rst_s_n), .wr_i(h_ring_wr),
    .data_i(h_ring_data), .ring_q(h_ring_q));

  mbx_ring_reg #(.W(RING_W)) u_s_ring (
    .clk(clk), .rst_n(rst_s_n), .wr_i(s_ring_wr),
    .data_i(s_ring_data), .ring_q(s_ring_q));

  // host status: slave doorbells low, local events above
  always_comb begin
    h_set             = '0;
    h_set[RING_W-1:0] = s_ring_q;
    h_set[H_PKT_BIT]  = h_pkt_ready;
    h_set[H_OVF_BIT]  = h_rxbuf_ovf;
    h_set[H_UDF_BIT]  = h_txbuf_udf;
    s_set             = '0;
    s_set[RING_W-1:0] = h_ring_q;
    s_set[S_SEND_BIT] = s_send_dscr_err;
    s_set[S_RECV_BIT] = s_recv_dscr_err;
  end

  mbx_irq_bank #(.W(H_STAT_W)) u_h_bank (
    .clk(clk), .rst_n(rst_s_n), .set_i(h_set),
    .clr_wr_i(h_clr_wr), .clr_data_i(h_clr_data),
    .en_wr_i(h_en_wr), .en_data_i(h_en_data),
    .raw_o(h_raw), .masked_o(h_masked), .irq_o(h_irq));

  mbx_irq_bank #(.W(S_STAT_W)) u_s_bank (
    .clk(clk), .rst_n(rst_s_n), .set_i(s_set),
    .clr_wr_i(s_clr_wr), .clr_data_i(s_clr_data),
    .en_wr_i(s_en_wr), .en_data_i(s_en_data),
    .raw_o(s_raw), .masked_o(s_masked), .irq_o(s_irq));

  assert_h_to_s_doorbell_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (|h_ring_q) |=> ((s_raw[RING_W-1:0] & $past(h_ring_q)) == $past(h_ring_q)));
  assert_s_to_h_doorbell_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (|s_ring_q) |=> ((h_raw[RING_W-1:0] & $past(s_ring_q)) == $past(s_ring_q)));
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_s_n |-> (h_raw == '0 && s_raw == '0 && !h_irq && !s_irq));
endmodule

// File: tb/dbell_irq_mailbox_tb.sv
`timescale 1ns/1ps
module dbell_irq_mailbox_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic        h_ring_wr, h_en_wr, h_clr_wr, h_pkt_ready, h_rxbuf_ovf, h_txbuf_udf;
  logic [7:0]  h_ring_data, h_ring_q;
  logic [10:0] h_en_data, h_clr_data, h_raw, h_masked;
  logic        h_irq;
  logic        s_ring_wr, s_en_wr, s_clr_wr, s_send_dscr_err, s_recv_dscr_err;
  logic [7:0]  s_ring_data, s_ring_q;
  logic [9:0]  s_en_data, s_clr_data, s_raw, s_masked;
  logic        s_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit cmp_on = 0;

  // reference model state
  logic [7:0]  m_hring, m_sring;
  logic [10:0] m_hraw, m_hen;
  logic [9:0]  m_sraw, m_sen;
  int          m_cnt;

  always #4 clk = ~clk;

  dbell_irq_mailbox dut_i (
    .clk(clk), .rst_n(rst_n),
    .h_ring_wr(h_ring_wr), .h_ring_data(h_ring_data), .h_ring_q(h_ring_q),
    .h_en_wr(h_en_wr), .h_en_data(h_en_data),
    .h_clr_wr(h_clr_wr), .h_clr_data(h_clr_data),
    .h_pkt_ready(h_pkt_ready), .h_rxbuf_ovf(h_rxbuf_ovf), .h_txbuf_udf(h_txbuf_udf),
    .h_raw(h_raw), .h_masked(h_masked), .h_irq(h_irq),
    .s_ring_wr(s_ring_wr), .s_ring_data(s_ring_data), .s_ring_q(s_ring_q),
    .s_en_wr(s_en_wr), .s_en_data(s_en_data),
    .s_clr_wr(s_clr_wr), .s_clr_data(s_clr_data),
    .s_send_dscr_err(s_send_dscr_err), .s_recv_dscr_err(s_recv_dscr_err),
    .s_raw(s_raw), .s_masked(s_masked), .s_irq(s_irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural model: reset release after two synchronizer edges
  always @(posedge clk) begin
    logic [10:0] hset;
    logic [9:0]  sset;
    if (!rst_n) begin
      m_cnt = 0; m_hring = '0; m_sring = '0;
      m_hraw = '0; m_hen = '0; m_sraw = '0; m_sen = '0;
    end else if (m_cnt < 2) begin
      m_cnt++;
    end else begin
      hset = {h_txbuf_udf, h_rxbuf_ovf, h_pkt_ready, m_sring};
      sset = {s_recv_dscr_err, s_send_dscr_err, m_hring};
      m_hraw = (m_hraw & ~(h_clr_wr ? h_clr_data : 11'h0)) | hset;
      m_sraw = (m_sraw & ~(s_clr_wr ? s_clr_data : 10'h0)) | sset;
      if (h_en_wr) m_hen = h_en_data;
      if (s_en_wr) m_sen = s_en_data;
      m_hring = h_ring_wr ? h_ring_data : 8'h0;
      m_sring = s_ring_wr ? s_ring_data : 8'h0;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R2 h_ring_q", 32'(h_ring_q), 32'(m_hring));
      chk("R2 s_ring_q", 32'(s_ring_q), 32'(m_sring));
      chk("R6 h_raw", 32'(h_raw), 32'(m_hraw));
      chk("R6 s_raw", 32'(s_raw), 32'(m_sraw));
      chk("R9 h_masked", 32'(h_masked), 32'(m_hraw & m_hen));
      chk("R9 s_masked", 32'(s_masked), 32'(m_sraw & m_sen));
      chk("R10 h_irq", 32'(h_irq), 32'(|(m_hraw & m_hen)));
      chk("R10 s_irq", 32'(s_irq), 32'(|(m_sraw & m_sen)));
    end
  end

  task automatic idle_inputs;
    h_ring_wr = 0; h_ring_data = '0; h_en_wr = 0; h_en_data = '0;
    h_clr_wr = 0; h_clr_data = '0; h_pkt_ready = 0; h_rxbuf_ovf = 0; h_txbuf_udf = 0;
    s_ring_wr = 0; s_ring_data = '0; s_en_wr = 0; s_en_data = '0;
    s_clr_wr = 0; s_clr_data = '0; s_send_dscr_err = 0; s_recv_dscr_err = 0;
  endtask

  // one edge passes; inputs return to idle at the following falling edge
  task automatic step;
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 h_raw in reset", 32'(h_raw), 0);
    chk("R1 irq in reset", 32'({h_irq, s_irq}), 0);
    rst_n = 1;
    step();
    step();
    chk("R1 ring idle after release", 32'({h_ring_q, s_ring_q}), 0);
    step();
    cmp_on = 1;

    // R2/R3: host rings slave with 0x05
    h_ring_wr = 1; h_ring_data = 8'h05; step();
    chk("R2 readback", 32'(h_ring_q), 32'h05);
    chk("R3 not yet set", 32'(s_raw), 0);
    step();
    chk("R2 self clear", 32'(h_ring_q), 0);
    chk("R3 host->slave", 32'(s_raw), 32'h005);

    s_ring_wr = 1; s_ring_data = 8'h80; step(); step();
    chk("R3 slave->host", 32'(h_raw), 32'h080);

    h_pkt_ready = 1; h_rxbuf_ovf = 1; h_txbuf_udf = 1; step();
    chk("R4 host events", 32'(h_raw), 32'h780);

    s_send_dscr_err = 1; s_recv_dscr_err = 1; step();
    chk("R5 slave events", 32'(s_raw), 32'h305);

    repeat (3) step();
    chk("R6 host sticky", 32'(h_raw), 32'h780);
    chk("R6 slave sticky", 32'(s_raw), 32'h305);

    h_clr_wr = 1; h_clr_data = 11'h080; step();
    chk("R7 clear one", 32'(h_raw), 32'h700);
    h_clr_wr = 1; h_clr_data = 11'h000; step();
    chk("R7 zero clear", 32'(h_raw), 32'h700);
    s_clr_wr = 1; s_clr_data = 10'h3FF; step();
    chk("R7 slave clear all", 32'(s_raw), 0);

    h_clr_wr = 1; h_clr_data = 11'h700; h_rxbuf_ovf = 1; step();
    chk("R8 event set beats clear", 32'(h_raw), 32'h200);
    s_ring_wr = 1; s_ring_data = 8'h01; step();
    h_clr_wr = 1; h_clr_data = 11'h001; step();
    chk("R8 doorbell set beats clear", 32'(h_raw), 32'h201);

    h_en_wr = 1; h_en_data = 11'h001; step();
    chk("R9 masked", 32'(h_masked), 32'h001);
    chk("R10 irq high", 32'(h_irq), 1);
    h_en_wr = 1; h_en_data = 11'h400; step();
    chk("R9 enable replaced", 32'(h_masked), 0);
    chk("R10 irq low", 32'(h_irq), 0);
    h_en_wr = 1; h_en_data = 11'h200; step();
    chk("R10 irq on bit9", 32'(h_irq), 1);
    h_clr_wr = 1; h_clr_data = 11'h200; step();
    chk("R10 irq follows clear", 32'(h_irq), 0);
    chk("R7 remaining", 32'(h_raw), 32'h001);

    s_en_wr = 1; s_en_data = 10'h3FF; step();
    chk("R10 slave irq idle", 32'(s_irq), 0);
    h_ring_wr = 1; h_ring_data = 8'h00; step(); step();
    chk("R11 zero ring", 32'(s_raw), 0);
    h_ring_wr = 1; h_ring_data = 8'h10; step(); step();
    chk("R10 slave irq", 32'(s_irq), 1);
    chk("R3 bit4", 32'(s_raw), 32'h010);

    repeat (4) step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule